// File: doc/BRIEF.md
# Timer Compare Unit with Period Trigger

This block contains a 16-bit up-counting timer, a 16-bit compare register and a 4-bit mode field, all loaded through a byte-wide register write port. Every cycle the timer is tested for exact equality with the compare register. When compare is enabled, a hit sets a sticky interrupt flag. Depending on the mode, the hit also sets or clears a compare output latch, or restarts the timer and emits a one-cycle conversion-start strobe.

In the trigger mode the compare register acts as a period register. The timer counts from zero up to the compare value inclusive and then returns to zero, and this return does not count as an overflow. A normal wrap from all ones to zero sets a separate sticky overflow flag. The compare latch reaches the pin only while the active-low output-enable input is low.

Write address map (`wrAddr`):

| Address | Effect of a write |
|---|---|
| 0 | timer low byte |
| 1 | timer high byte |
| 2 | compare low byte |
| 3 | compare high byte |
| 4 | mode field, taken from `wrData[3:0]` |
| 5 | flag clear: bit 0 clears the compare flag, bit 1 clears the overflow flag |

Top module: `tmr_cmp_unit`

## Requirements
- R1: A hit is an exact equality of all 16 timer bits with all 16 compare bits. While `timerRun` is 1 and no timer byte is being written, the timer advances by one each clock. A timer whose low byte equals the compare low byte but whose high byte differs causes no hit.
- R2: Mode 1000 sets the latch on a hit. Writing 1000 forces the latch low. A hit in timer cycle t makes `cmpPin` 1 from the next cycle.
- R3: Mode 1001 clears the latch on a hit. Writing 1001 forces the latch high. A hit makes `cmpPin` 0 from the next cycle.
- R4: In the modes 1000 to 1011, a hit sets `cmpFlag` in the next cycle. The flag stays set until a write to address 5 with bit 0 set. With any other mode value, no hit is detected and `cmpFlag` stays 0.
- R5: In mode 1010 a hit sets `cmpFlag` and leaves the latch, and therefore `cmpPin`, unchanged. Entering mode 1010 does not change the latch.
- R6: In mode 1011 a hit returns the timer to 0 at the next edge, so one period lasts compare+1 cycles. In the cycle in which the timer reads 0, `convStart` is 1 for one cycle. This reset does not set `ovfFlag`, and it leaves the latch unchanged.
- R7: When the timer advances from FFFFh, it becomes 0000h and sets `ovfFlag` in the next cycle. The flag stays set until a write to address 5 with bit 1 set.
- R8: Writing mode 0000 forces the latch low.
- R9: While `outEnN` is 1, `cmpPin` and `cmpPinOe` are both 0. While `outEnN` is 0, `cmpPinOe` is 1 and `cmpPin` follows the latch.
- R10: After reset, the timer, the compare register, the mode and the latch are 0, and all outputs are 0 except `cmpPinOe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| wrEn | input | 1 | register write strobe |
| wrAddr | input | 3 | register write address |
| wrData | input | 8 | register write data |
| timerRun | input | 1 | timer counts while 1 |
| outEnN | input | 1 | active-low pin output enable |
| cmpPin | output | 1 | gated compare latch |
| cmpPinOe | output | 1 | pin drive enable |
| cmpFlag | output | 1 | sticky compare interrupt flag |
| ovfFlag | output | 1 | sticky timer overflow flag |
| convStart | output | 1 | one-cycle conversion-start strobe |

## Verification
The timer cannot be read back. A wrong timer count or a wrong compare value therefore shows up only as a hit that occurs in the wrong cycle. The bench detects this because it predicts the exact cycle in which the pin, the compare flag or the strobe changes, one cycle after the timer reaches the compare value. An error in the period restart shows up within one period, as a misplaced second strobe or a spurious overflow. A wrong mode decode flips the latch at mode entry or at the first hit.

// File: rtl/tcu_pkg.sv
package tcu_pkg;
  localparam logic [3:0] MODE_OFF   = 4'b0000;
  localparam logic [3:0] MODE_SETHI = 4'b1000;
  localparam logic [3:0] MODE_SETLO = 4'b1001;
  localparam logic [3:0] MODE_SWI   = 4'b1010;
  localparam logic [3:0] MODE_SPEV  = 4'b1011;

  localparam logic [2:0] ADR_TLO  = 3'd0;
  localparam logic [2:0] ADR_THI  = 3'd1;
  localparam logic [2:0] ADR_CLO  = 3'd2;
  localparam logic [2:0] ADR_CHI  = 3'd3;
  localparam logic [2:0] ADR_MODE = 3'd4;
  localparam logic [2:0] ADR_FCLR = 3'd5;

  typedef struct packed {
    logic ldTmrLo;
    logic ldTmrHi;
    logic ldCmpLo;
    logic ldCmpHi;
    logic tmrClr;
  } dpCtl_t;
endpackage

// File: rtl/tcu_datapath.sv
module tcu_datapath
  import tcu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  dpCtl_t                ctl,
  input  logic [DATA_W-1:0]     wrData,
  input  logic                  timerRun,
  output logic                  eq,
  output logic                  wrapEv,
  output logic [2*DATA_W-1:0]   timerQ
);
  localparam int TMR_W = 2 * DATA_W;

  logic [TMR_W-1:0] cmpQ;
  logic             anyTmrLd;

  assign anyTmrLd = ctl.ldTmrLo | ctl.ldTmrHi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timerQ <= '0;
    end else if (anyTmrLd) begin
      if (ctl.ldTmrLo) timerQ[DATA_W-1:0] <= wrData;
      if (ctl.ldTmrHi) timerQ[TMR_W-1:DATA_W] <= wrData;
    end else if (ctl.tmrClr) begin
      timerQ <= '0;
    end else if (timerRun) begin
      timerQ <= timerQ + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmpQ <= '0;
    end else begin
      if (ctl.ldCmpLo) cmpQ[DATA_W-1:0] <= wrData;
      if (ctl.ldCmpHi) cmpQ[TMR_W-1:DATA_W] <= wrData;
    end
  end

  assign eq     = (timerQ == cmpQ);
  assign wrapEv = timerRun & ~anyTmrLd & ~ctl.tmrClr & (&timerQ);
endmodule

// File: rtl/tcu_control.sv
module tcu_control
  import tcu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              eq,
  input  logic              wrapEv,
  output dpCtl_t            ctl,
  output logic [3:0]        modeQ,
  output logic              latchQ,
  output logic              cmpFlagQ,
  output logic              ovfFlagQ,
  output logic              convStartQ
);
  logic modeWr, clrWr, active, hit;

  assign modeWr = wrEn && (wrAddr == ADR_MODE);
  assign clrWr  = wrEn && (wrAddr == ADR_FCLR);
  assign active = (modeQ[3:2] == 2'b10);
  assign hit    = eq && active;

  always_comb begin
    ctl.ldTmrLo = wrEn && (wrAddr == ADR_TLO);
    ctl.ldTmrHi = wrEn && (wrAddr == ADR_THI);
    ctl.ldCmpLo = wrEn && (wrAddr == ADR_CLO);
    ctl.ldCmpHi = wrEn && (wrAddr == ADR_CHI);
    ctl.tmrClr  = hit && (modeQ == MODE_SPEV);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modeQ      <= MODE_OFF;
      latchQ     <= 1'b0;
      cmpFlagQ   <= 1'b0;
      ovfFlagQ   <= 1'b0;
      convStartQ <= 1'b0;
    end else begin
      if (modeWr) modeQ <= wrData[3:0];
      if (modeWr) begin
        case (wrData[3:0])
          MODE_OFF, MODE_SETHI: latchQ <= 1'b0;
          MODE_SETLO:           latchQ <= 1'b1;
          default:              latchQ <= latchQ;
        endcase
      end else if (hit) begin
        if (modeQ == MODE_SETHI) latchQ <= 1'b1;
        else if (modeQ == MODE_SETLO) latchQ <= 1'b0;
      end
      cmpFlagQ   <= hit | (cmpFlagQ & ~(clrWr & wrData[0]));
      ovfFlagQ   <= wrapEv | (ovfFlagQ & ~(clrWr & wrData[1]));
      convStartQ <= ctl.tmrClr;
    end
  end
endmodule

// File: rtl/tmr_cmp_unit.sv
module tmr_cmp_unit
  import tcu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              timerRun,
  input  logic              outEnN,
  output logic              cmpPin,
  output logic              cmpPinOe,
  output logic              cmpFlag,
  output logic              ovfFlag,
  output logic              convStart
);
  localparam int TMR_W = 2 * DATA_W;

  dpCtl_t           ctl;
  logic             eqSig, wrapEv, latchQ;
  logic [3:0]       modeQ;
  logic [TMR_W-1:0] timerQ;

  tcu_control #(.DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .eq(eqSig), .wrapEv(wrapEv), .ctl(ctl), .modeQ(modeQ), .latchQ(latchQ),
    .cmpFlagQ(cmpFlag), .ovfFlagQ(ovfFlag), .convStartQ(convStart)
  );

  tcu_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .wrData(wrData), .timerRun(timerRun),
    .eq(eqSig), .wrapEv(wrapEv), .timerQ(timerQ)
  );

  assign cmpPinOe = ~outEnN;
  assign cmpPin   = latchQ & ~outEnN;
endmodule

// File: rtl/tcu_checker.sv
module tcu_checker
  import tcu_pkg::*;
#(
  parameter int TMR_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wrEn,
  input logic [2:0]       wrAddr,
  input logic [3:0]       wrMode,
  input logic             outEnN,
  input logic [3:0]       modeQ,
  input logic             eq,
  input logic [TMR_W-1:0] timerQ,
  input logic             latchQ,
  input logic             cmpPin,
  input logic             cmpPinOe,
  input logic             cmpFlag,
  input logic             ovfFlag,
  input logic             convStart
);
  assert_flag_on_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (eq && modeQ[3:2] == 2'b10) |=> cmpFlag);

  assert_swi_pin_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (modeQ == MODE_SWI && !(wrEn && wrAddr == ADR_MODE)) |=> $stable(latchQ));

  assert_period_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (eq && modeQ == MODE_SPEV && !(wrEn && wrAddr < 3'd2)) |=> (timerQ == '0));

  assert_strobe_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    convStart |-> $past(eq && modeQ == MODE_SPEV));

  assert_ovf_only_on_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovfFlag) |-> ($past(timerQ) == '1));

  assert_off_latch_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && wrAddr == ADR_MODE && wrMode == MODE_OFF) |=> !latchQ);

  assert_pin_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    outEnN |-> (!cmpPin && !cmpPinOe));
endmodule

bind tmr_cmp_unit tcu_checker #(.TMR_W(2 * DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrMode(wrData[3:0]),
  .outEnN(outEnN), .modeQ(modeQ), .eq(eqSig), .timerQ(timerQ), .latchQ(latchQ),
  .cmpPin(cmpPin), .cmpPinOe(cmpPinOe), .cmpFlag(cmpFlag), .ovfFlag(ovfFlag),
  .convStart(convStart)
);

// File: tb/tmr_cmp_unit_tb_top.sv
module tmr_cmp_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic timerRun = 1'b0;
  logic outEnN = 1'b0;
  logic cmpPin, cmpPinOe, cmpFlag, ovfFlag, convStart;

  tmr_cmp_unit dut_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .timerRun(timerRun), .outEnN(outEnN), .cmpPin(cmpPin), .cmpPinOe(cmpPinOe),
    .cmpFlag(cmpFlag), .ovfFlag(ovfFlag), .convStart(convStart)
  );

  always #10 clk = ~clk;

  localparam int S_PIN = 0, S_OE = 1, S_CF = 2, S_OF = 3, S_CS = 4;

  typedef struct {
    int    cyc;
    int    sel;
    logic  exp;
    string req;
  } item_t;

  item_t sbQ[$];
  int cyc = 0;
  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  function automatic logic getSig(int sel);
    case (sel)
      S_PIN:   return cmpPin;
      S_OE:    return cmpPinOe;
      S_CF:    return cmpFlag;
      S_OF:    return ovfFlag;
      default: return convStart;
    endcase
  endfunction

  // monitor: sample 5 ns after each rising edge
  initial forever begin
    @(posedge clk);
    cyc++;
    #5;
    while (sbQ.size() > 0 && sbQ[0].cyc <= cyc) begin
      item_t it;
      logic act;
      it = sbQ.pop_front();
      act = getSig(it.sel);
      nChecks++;
      if (act !== it.exp) begin
        nFails++;
        $display("FAIL %s cycle %0d signal %0d: actual %b expected %b",
                 it.req, cyc, it.sel, act, it.exp);
      end
    end
  end

  task automatic expectAt(int at, int sel, logic val, string req);
    item_t it;
    it.cyc = at; it.sel = sel; it.exp = val; it.req = req;
    sbQ.push_back(it);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setTimer(logic [15:0] v);
    wr(3'd1, v[15:8]);
    wr(3'd0, v[7:0]);
  endtask

  task automatic setCmp(logic [15:0] v);
    wr(3'd3, v[15:8]);
    wr(3'd2, v[7:0]);
  endtask

  task automatic idle(int k);
    repeat (k) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    expectAt(cyc + 1, S_PIN, 1'b0, "R10");
    expectAt(cyc + 1, S_OE,  1'b1, "R10");
    expectAt(cyc + 1, S_CF,  1'b0, "R10");
    expectAt(cyc + 1, S_OF,  1'b0, "R10");
    expectAt(cyc + 1, S_CS,  1'b0, "R10");
    idle(2);

    // R2 set on match
    setCmp(16'h0010);
    setTimer(16'h000C);
    wr(3'd4, 8'h08);
    expectAt(cyc + 1, S_PIN, 1'b0, "R2");
    timerRun = 1'b1; n = cyc;
    expectAt(n + 4, S_PIN, 1'b0, "R2");
    expectAt(n + 4, S_CF,  1'b0, "R4");
    expectAt(n + 5, S_PIN, 1'b1, "R2");
    expectAt(n + 5, S_CF,  1'b1, "R4");
    idle(8); timerRun = 1'b0;
    expectAt(cyc + 2, S_CF, 1'b1, "R4");
    idle(3);

    // R8 mode off forces latch low
    wr(3'd4, 8'h00);
    expectAt(cyc + 1, S_PIN, 1'b0, "R8");
    expectAt(cyc + 1, S_CF,  1'b1, "R4");
    idle(2);
    wr(3'd5, 8'h01);
    expectAt(cyc + 1, S_CF, 1'b0, "R4");
    idle(2);

    // R3 clear on match
    wr(3'd4, 8'h09);
    expectAt(cyc + 1, S_PIN, 1'b1, "R3");
    idle(1);
    setTimer(16'h000C);
    timerRun = 1'b1; n = cyc;
    expectAt(n + 4, S_PIN, 1'b1, "R3");
    expectAt(n + 5, S_PIN, 1'b0, "R3");
    expectAt(n + 5, S_CF,  1'b1, "R3");
    idle(8); timerRun = 1'b0;
    idle(2);

    // R5 software interrupt only
    wr(3'd5, 8'h01);
    wr(3'd4, 8'h09);
    wr(3'd4, 8'h0A);
    expectAt(cyc + 1, S_PIN, 1'b1, "R5");
    expectAt(cyc + 1, S_CF,  1'b0, "R5");
    idle(1);
    setTimer(16'h000C);
    timerRun = 1'b1; n = cyc;
    expectAt(n + 4, S_CF,  1'b0, "R5");
    expectAt(n + 5, S_CF,  1'b1, "R5");
    expectAt(n + 5, S_PIN, 1'b1, "R5");
    expectAt(n + 7, S_PIN, 1'b1, "R5");
    idle(8); timerRun = 1'b0;
    idle(2);

    // R9 output enable gating
    outEnN = 1'b1;
    expectAt(cyc + 1, S_PIN, 1'b0, "R9");
    expectAt(cyc + 1, S_OE,  1'b0, "R9");
    idle(2);
    outEnN = 1'b0;
    expectAt(cyc + 1, S_PIN, 1'b1, "R9");
    expectAt(cyc + 1, S_OE,  1'b1, "R9");
    idle(2);

    // R1 exact 16-bit equality: low byte matches, high byte differs
    wr(3'd5, 8'h01);
    setCmp(16'h0105);
    setTimer(16'h0004);
    timerRun = 1'b1; n = cyc;
    expectAt(n + 2, S_CF, 1'b0, "R1");
    expectAt(n + 5, S_CF, 1'b0, "R1");
    idle(4); timerRun = 1'b0;
    idle(2);

    // R6 special event trigger with period compare+1
    setCmp(16'h0005);
    setTimer(16'h0000);
    wr(3'd4, 8'h0B);
    timerRun = 1'b1; n = cyc;
    expectAt(n + 5,  S_CS,  1'b0, "R6");
    expectAt(n + 6,  S_CS,  1'b1, "R6");
    expectAt(n + 6,  S_CF,  1'b1, "R6");
    expectAt(n + 7,  S_CS,  1'b0, "R6");
    expectAt(n + 11, S_CS,  1'b0, "R6");
    expectAt(n + 12, S_CS,  1'b1, "R6");
    expectAt(n + 12, S_PIN, 1'b1, "R6");
    expectAt(n + 13, S_CS,  1'b0, "R6");
    expectAt(n + 13, S_OF,  1'b0, "R6");
    idle(14); timerRun = 1'b0;
    idle(2);

    // R7 overflow wrap, and R4 no hit while compare disabled
    wr(3'd4, 8'h00);
    wr(3'd5, 8'h03);
    setTimer(16'hFFFD);
    timerRun = 1'b1; n = cyc;
    expectAt(n + 2, S_OF, 1'b0, "R7");
    expectAt(n + 3, S_OF, 1'b1, "R7");
    expectAt(n + 9, S_CF, 1'b0, "R4");
    expectAt(n + 9, S_CS, 1'b0, "R4");
    expectAt(n + 11, S_OF, 1'b1, "R7");
    idle(12);
    wr(3'd5, 8'h02);
    expectAt(cyc + 1, S_OF, 1'b0, "R7");
    idle(2); timerRun = 1'b0;

    while (sbQ.size() > 0) @(negedge clk);
    idle(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule